// File: doc/BRIEF.md
# Cross-Lane Swizzle Unit

The unit moves 32-bit words between the lanes of a 32-lane group. Every lane computes the index of the lane it reads from. That index follows from the lane's own 5-bit id and from one of five patterns: a four-way permute repeated in every quad, a per-bit rewrite of the lane id, a broadcast within power-of-two groups, an exchange of neighbouring groups, or a reversal within groups. A crossbar then fetches each lane's word from its source lane. When the source lane is switched off in the active mask, the lane gets zero instead.

The unit registers its result one cycle after an accepted input. When the parameters of the chosen pattern are not legal, the unit raises an error flag for that single result and forwards the input words unchanged. The unit has no states beyond the registered result. It accepts one input per cycle with no back-pressure, so a producer may issue work on consecutive cycles.

Top module: `swz_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_err` and `out_data` are all cleared to zero.
- R2: The cycle after `in_valid` is high, `out_valid` is high. The cycle after `in_valid` is low, `out_valid` and `out_err` are low and `out_data` keeps its previous value.
- R3: Quad mode (`in_mode` = 0) splits the lanes into quads. Lane `l` reads lane `4*(l/4) + q`, where `q` is the 2-bit field `in_quad_sel[2*(l%4)+1 : 2*(l%4)]`.
- R4: Bit-rule mode (`in_mode` = 1) builds the source id bit by bit. Bit `b` of the source id is set by the field `in_bit_rule[2b+1:2b]`: 0 forces it to zero, 1 forces it to one, 2 copies bit `b` of the lane id, 3 copies that bit inverted.
- R5: Broadcast mode (`in_mode` = 2) uses a group size of `2^in_grp_log2`, with `in_grp_log2` from 1 to 5. Every lane reads lane `in_bcast_lane` of its own group.
- R6: Swap mode (`in_mode` = 3) uses `in_grp_log2` from 0 to 4. Lane `l` reads lane `l XOR 2^in_grp_log2`, which exchanges neighbouring groups of that size.
- R7: Reverse mode (`in_mode` = 4) uses `in_grp_log2` from 1 to 5. Lane `l` reads lane `l XOR (2^in_grp_log2 - 1)`, which reverses the lane order inside each group.
- R8: A lane whose source lane has a 0 bit in `in_active` receives zero.
- R9: The following inputs are illegal: an `in_mode` of 5, 6 or 7; an `in_grp_log2` outside the range of the selected mode; in broadcast mode, an `in_bcast_lane` not below the group size. For an illegal input, `out_err` is high for that one result and `out_data` equals `in_data`, unchanged and unmasked.
- R10: With every pattern input at zero (quad mode, all selectors 0), each lane reads lane 0 of its own quad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word set is present this cycle |
| in_mode | input | 3 | Pattern select: 0 quad, 1 bit-rule, 2 broadcast, 3 swap, 4 reverse |
| in_quad_sel | input | 8 | Four 2-bit in-quad source selectors, position 0 in the low bits |
| in_bit_rule | input | 2*LW | One 2-bit rule per lane-id bit, bit 0 in the low bits |
| in_grp_log2 | input | 3 | log2 of the group size for broadcast, swap and reverse |
| in_bcast_lane | input | LW | Lane inside each group that is broadcast |
| in_active | input | LANES | Per-lane active mask, lane 0 in bit 0 |
| in_data | input | LANES*DW | Lane words, lane 0 in the low bits |
| out_valid | output | 1 | Registered result present |
| out_err | output | 1 | Registered result came from an illegal input |
| out_data | output | LANES*DW | Registered permuted lane words |

## Verification
The bench uses the default parameters, LANES = 32 and DW = 32. With these values every lane-id bit takes part in the bit-rule tests. They also allow the widest group size, 32, in broadcast and reverse, and the widest swap distance, 16. The lane words carry a distinct pattern in each lane, so a misrouted lane shows up as a wrong word. Partial active masks show which lanes were zeroed because their source lane was inactive.

// File: rtl/swz_pkg.sv
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_QUAD  = 3'd0,
        SWZ_BITS  = 3'd1,
        SWZ_BCAST = 3'd2,
        SWZ_SWAP  = 3'd3,
        SWZ_REV   = 3'd4
    } swz_mode_e;

    typedef enum logic [1:0] {
        RULE_ZERO = 2'd0,
        RULE_ONE  = 2'd1,
        RULE_KEEP = 2'd2,
        RULE_FLIP = 2'd3
    } swz_rule_e;

endpackage

// File: rtl/swz_src_decode.sv
module swz_src_decode
    import swz_pkg::*;
#(
    parameter int LANES = 32,
    localparam int LW = $clog2(LANES)
) (
    input  logic [2:0]          mode,
    input  logic [7:0]          quad_sel,
    input  logic [2*LW-1:0]     bit_rule,
    input  logic [2:0]          grp_log2,
    input  logic [LW-1:0]       bcast_lane,
    output logic [LANES*LW-1:0] src_idx,
    output logic                illegal
);

    logic [LW-1:0] low_mask;
    logic [LW-1:0] grp_bit;

    always_comb begin
        low_mask = LW'((32'd1 << grp_log2) - 32'd1);
        grp_bit  = LW'(32'd1 << grp_log2);
    end

    // Legality of the pattern, shared by all lanes
    always_comb begin
        unique case (mode)
            SWZ_QUAD,
            SWZ_BITS:  illegal = 1'b0;
            SWZ_BCAST: illegal = (grp_log2 == 3'd0) || (int'(grp_log2) > LW)
                                 || ((bcast_lane & ~low_mask) != '0);
            SWZ_SWAP:  illegal = (int'(grp_log2) >= LW);
            SWZ_REV:   illegal = (grp_log2 == 3'd0) || (int'(grp_log2) > LW);
            default:   illegal = 1'b1;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [LW-1:0] ID = LW'(l);
        logic [LW-1:0] src;

        always_comb begin
            src = ID;
            unique case (mode)
                SWZ_QUAD:  src = {ID[LW-1:2], quad_sel[2*(l%4) +: 2]};
                SWZ_BITS: begin
                    for (int b = 0; b < LW; b++) begin
                        unique case (bit_rule[2*b +: 2])
                            RULE_ZERO: src[b] = 1'b0;
                            RULE_ONE:  src[b] = 1'b1;
                            RULE_KEEP: src[b] = ID[b];
                            default:   src[b] = ~ID[b];
                        endcase
                    end
                end
                SWZ_BCAST: src = (ID & ~low_mask) | (bcast_lane & low_mask);
                SWZ_SWAP:  src = ID ^ grp_bit;
                SWZ_REV:   src = ID ^ low_mask;
                default:   src = ID;
            endcase
        end

        assign src_idx[l*LW +: LW] = src;
    end

endmodule

// File: rtl/swz_xbar.sv
module swz_xbar #(
    parameter int LANES = 32,
    parameter int DW = 32,
    localparam int LW = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] data,
    input  logic [LANES-1:0]    active,
    input  logic [LANES*LW-1:0] src_idx,
    output logic [LANES*DW-1:0] routed
);

    for (genvar l = 0; l < LANES; l++) begin : g_route
        logic [LW-1:0] idx;
        assign idx = src_idx[l*LW +: LW];
        assign routed[l*DW +: DW] = active[idx] ? data[idx*DW +: DW] : '0;
    end

endmodule

// File: rtl/swz_unit.sv
module swz_unit
    import swz_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW = 32,
    localparam int LW = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          in_mode,
    input  logic [7:0]          in_quad_sel,
    input  logic [2*LW-1:0]     in_bit_rule,
    input  logic [2:0]          in_grp_log2,
    input  logic [LW-1:0]       in_bcast_lane,
    input  logic [LANES-1:0]    in_active,
    input  logic [LANES*DW-1:0] in_data,
    output logic                out_valid,
    output logic                out_err,
    output logic [LANES*DW-1:0] out_data
);

    logic [LANES*LW-1:0] src_idx;
    logic                illegal;
    logic [LANES*DW-1:0] routed;

    swz_src_decode #(.LANES(LANES)) u_decode (
        .mode       (in_mode),
        .quad_sel   (in_quad_sel),
        .bit_rule   (in_bit_rule),
        .grp_log2   (in_grp_log2),
        .bcast_lane (in_bcast_lane),
        .src_idx    (src_idx),
        .illegal    (illegal)
    );

    swz_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
        .data    (in_data),
        .active  (in_active),
        .src_idx (src_idx),
        .routed  (routed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid & illegal;
            if (in_valid) begin
                out_data <= illegal ? in_data : routed;
            end
        end
    end

endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk #(
    parameter int LANES = 32,
    parameter int DW = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [2:0]          in_mode,
    input logic [LANES-1:0]    in_active,
    input logic [LANES*DW-1:0] in_data,
    input logic                out_valid,
    input logic                out_err,
    input logic [LANES*DW-1:0] out_data
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_err && $stable(out_data)));

    assert_bad_mode_passthru_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode > 3'd4) |=> (out_err && out_data == $past(in_data)));

    assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    assert_all_inactive_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_active == '0 && in_mode == 3'd0) |=> (out_data == '0 && !out_err));

endmodule

bind swz_unit swz_unit_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_active (in_active),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_data  (out_data)
);

// File: tb/swz_unit_bench.sv
`timescale 1ns/1ps
module swz_unit_bench;

    localparam int LANES = 32;
    localparam int DW = 32;
    localparam int LW = 5;

    typedef struct {
        logic [LANES*DW-1:0] d;
        logic                e;
        string               tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [2:0]          in_mode = '0;
    logic [7:0]          in_quad_sel = '0;
    logic [2*LW-1:0]     in_bit_rule = '0;
    logic [2:0]          in_grp_log2 = '0;
    logic [LW-1:0]       in_bcast_lane = '0;
    logic [LANES-1:0]    in_active = '0;
    logic [LANES*DW-1:0] in_data = '0;
    logic                out_valid;
    logic                out_err;
    logic [LANES*DW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    exp_t q[$];
    logic [LANES*DW-1:0] last_data = '0;

    always #2 clk = ~clk;

    swz_unit #(.LANES(LANES), .DW(DW)) u_swz_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_quad_sel(in_quad_sel), .in_bit_rule(in_bit_rule),
        .in_grp_log2(in_grp_log2), .in_bcast_lane(in_bcast_lane),
        .in_active(in_active), .in_data(in_data),
        .out_valid(out_valid), .out_err(out_err), .out_data(out_data)
    );

    function automatic logic [LANES*DW-1:0] lane_words(int seed);
        logic [LANES*DW-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*DW +: DW] = {16'(seed), 8'(l), 8'(~l)};
        return v;
    endfunction

    function automatic exp_t model(logic [2:0] m, logic [7:0] qs, logic [9:0] br,
                                   logic [2:0] g, logic [4:0] bl, logic [31:0] act,
                                   logic [LANES*DW-1:0] d);
        exp_t r;
        int gsz = 1 << g;
        bit bad;
        case (m)
            3'd0, 3'd1: bad = 0;
            3'd2: bad = (g < 1) || (g > 5) || (int'(bl) >= gsz);
            3'd3: bad = (g > 4);
            3'd4: bad = (g < 1) || (g > 5);
            default: bad = 1;
        endcase
        r.e = bad;
        r.tag = "";
        if (bad) begin
            r.d = d;
            return r;
        end
        for (int l = 0; l < LANES; l++) begin
            int s = 0;
            case (m)
                3'd0: s = (l / 4) * 4 + int'(qs[2*(l%4) +: 2]);
                3'd1: for (int b = 0; b < LW; b++) begin
                        case (br[2*b +: 2])
                            2'd0: s[b] = 1'b0;
                            2'd1: s[b] = 1'b1;
                            2'd2: s[b] = l[b];
                            default: s[b] = !l[b];
                        endcase
                      end
                3'd2: s = (l / gsz) * gsz + int'(bl);
                3'd3: s = ((l % (2*gsz)) < gsz) ? l + gsz : l - gsz;
                default: s = (l / gsz) * gsz + (gsz - 1 - (l % gsz));
            endcase
            r.d[l*DW +: DW] = act[s] ? d[s*DW +: DW] : '0;
        end
        return r;
    endfunction

    task automatic send(logic [2:0] m, logic [7:0] qs, logic [9:0] br, logic [2:0] g,
                        logic [4:0] bl, logic [31:0] act, int seed, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_quad_sel = qs; in_bit_rule = br;
        in_grp_log2 = g; in_bcast_lane = bl; in_active = act; in_data = lane_words(seed);
        e = model(m, qs, br, g, bl, act, lane_words(seed));
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pops expected items and compares with registered results
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected result: actual out_valid=1 expected out_valid=0");
            end else begin
                e = q.pop_front();
                if (out_data !== e.d || out_err !== e.e) begin
                    int bad_lane = 0;
                    for (int l = LANES - 1; l >= 0; l--)
                        if (out_data[l*DW +: DW] !== e.d[l*DW +: DW]) bad_lane = l;
                    failures++;
                    $display("FAIL %s lane %0d: actual %h err %b, expected %h err %b",
                             e.tag, bad_lane, out_data[bad_lane*DW +: DW], out_err,
                             e.d[bad_lane*DW +: DW], e.e);
                end
                last_data = e.d;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_data !== '0) begin
            failures++;
            $display("FAIL R1 reset: actual valid=%b err=%b data_nonzero=%b expected 0 0 0",
                     out_valid, out_err, |out_data);
        end
        @(negedge clk);
        rst = 1'b0;

        send(3'd0, 8'h00, 10'h000, 3'd0, 5'd0, 32'hFFFF_FFFF, 1, "R10 zero pattern");
        send(3'd0, 8'h1B, 10'h000, 3'd0, 5'd0, 32'hFFFF_FFFF, 2, "R3 quad reverse");
        send(3'd0, 8'h94, 10'h000, 3'd0, 5'd0, 32'hFFFF_FFFF, 3, "R3 quad mixed");
        send(3'd1, 8'h00, 10'h2AA, 3'd0, 5'd0, 32'hFFFF_FFFF, 4, "R4 keep all");
        send(3'd1, 8'h00, 10'h3FF, 3'd0, 5'd0, 32'hFFFF_FFFF, 5, "R4 flip all");
        send(3'd1, 8'h00, 10'h2A4, 3'd0, 5'd0, 32'hFFFF_FFFF, 6, "R4 mixed rules");
        send(3'd2, 8'h00, 10'h000, 3'd2, 5'd3, 32'hFFFF_FFFF, 7, "R5 group 4 lane 3");
        send(3'd2, 8'h00, 10'h000, 3'd5, 5'd31, 32'hFFFF_FFFF, 8, "R5 group 32 lane 31");
        send(3'd2, 8'h00, 10'h000, 3'd1, 5'd1, 32'hFFFF_FFFF, 9, "R5 group 2 lane 1");
        send(3'd3, 8'h00, 10'h000, 3'd0, 5'd0, 32'hFFFF_FFFF, 10, "R6 swap 1");
        send(3'd3, 8'h00, 10'h000, 3'd4, 5'd0, 32'hFFFF_FFFF, 11, "R6 swap 16");
        send(3'd3, 8'h00, 10'h000, 3'd2, 5'd0, 32'hFFFF_FFFF, 12, "R6 swap 4");
        send(3'd4, 8'h00, 10'h000, 3'd1, 5'd0, 32'hFFFF_FFFF, 13, "R7 reverse 2");
        send(3'd4, 8'h00, 10'h000, 3'd5, 5'd0, 32'hFFFF_FFFF, 14, "R7 reverse 32");
        send(3'd4, 8'h00, 10'h000, 3'd3, 5'd0, 32'hFFFF_FFFF, 15, "R7 reverse 8");
        send(3'd0, 8'hE4, 10'h000, 3'd0, 5'd0, 32'h0F0F_00FF, 16, "R8 identity partial mask");
        send(3'd3, 8'h00, 10'h000, 3'd1, 5'd0, 32'hA5A5_3C3C, 17, "R8 swap partial mask");
        send(3'd0, 8'h1B, 10'h000, 3'd0, 5'd0, 32'h0000_0000, 18, "R8 all inactive");
        send(3'd6, 8'h00, 10'h000, 3'd0, 5'd0, 32'h0000_FFFF, 19, "R9 bad mode");
        send(3'd2, 8'h00, 10'h000, 3'd2, 5'd4, 32'hFFFF_FFFF, 20, "R9 broadcast lane too big");
        send(3'd2, 8'h00, 10'h000, 3'd0, 5'd0, 32'hFFFF_FFFF, 21, "R9 broadcast group 1");
        send(3'd3, 8'h00, 10'h000, 3'd5, 5'd0, 32'hFFFF_FFFF, 22, "R9 swap 32");
        send(3'd4, 8'h00, 10'h000, 3'd0, 5'd0, 32'hFFFF_FFFF, 23, "R9 reverse group 1");
        send(3'd4, 8'h00, 10'h000, 3'd6, 5'd0, 32'hFFFF_FFFF, 24, "R9 reverse group 64");
        send(3'd1, 8'h00, 10'h155, 3'd0, 5'd0, 32'hFFFF_FFFF, 25, "R2 after error");
        idle(1);
        // R2: hold while idle
        @(negedge clk);
        in_mode = 3'd3; in_data = lane_words(99);
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_data !== last_data) begin
            failures++;
            $display("FAIL R2 idle hold: actual valid=%b err=%b same=%b expected 0 0 1",
                     out_valid, out_err, out_data === last_data);
        end
        idle(3);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing results: actual pending=%0d expected 0", q.size());
        end
        report();
    end

endmodule